// File: doc/BRIEF.md
# Flash Erase Command State Machine

This block is a synchronous, device-side model of the erase command interface of a small parallel NOR array. A controller under test drives active-low chip-enable, write-enable and output-enable strobes, an address and a command byte. A command is taken on each rising edge of the write strobe while chip-enable is low. The block walks through its setup, erase, post-erase and verify phases and holds a small register array. An erase sets that array to all ones.

An erase begins only after two consecutive `20h` bytes. It ends when the host sends `A0h`, or when an internal stop timer expires, whichever comes first. If the host ends the erase early, every byte at an address that is a multiple of `WEAK_STRIDE` is left at the value on `weak_val`, so that a controller's retry loop can be driven. In verify, an output-enable read returns the byte at the latched address, and another `20h` starts a re-erase.

Top module: `flash_erase_fsm`

## Requirements
- R1: After reset the machine is idle, `dq_oe` is 0, `dq_out` is 00h, and every stored byte reads 00h.
- R2: A command is taken only on a cycle where `we_n` is high after being low in the previous cycle and `ce_n` is low. A write strobe pulsed with `ce_n` high has no effect.
- R3: In idle, `20h` moves to erase-setup and changes no stored byte.
- R4: In erase-setup, `20h` starts erasing. Any other byte returns to idle and erases nothing.
- R5: While erasing, `A0h` ends the erase on that same edge, enters verify and latches its address for reads.
- R6: Once `ERASE_CYC` cycles have been spent erasing, the stop timer ends the erase by itself. A later `A0h` then enters verify without changing any data.
- R7: An erase whose `A0h` arrives on or after the timer's final cycle, including the very edge on which the timer expires, sets every byte to FFh.
- R8: An erase ended by `A0h` before the timer's final cycle sets bytes at addresses that are multiples of `WEAK_STRIDE` to the `weak_val` present on the ending edge, and sets all other bytes to FFh.
- R9: In verify, a cycle with `ce_n` and `oe_n` low drives the byte at the latched address on `dq_out`, with `dq_oe` = 1 one cycle later. In every other case `dq_oe` is 0, including reads attempted while erasing.
- R10: In verify, `20h` moves to erase-setup and `A0h` latches a new address. In idle, `A0h` enters verify without erasing.
- R11: While erasing, any byte other than `A0h` is ignored and the erase continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low; the command is taken on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Byte address |
| din | input | 8 | Command byte |
| weak_val | input | 8 | Value left in designated bytes by a cut-short erase |
| dq_out | output | 8 | Read data, 00h when not driven |
| dq_oe | output | 1 | Data bus drive enable; 0 means tri-stated |

## Verification
The host's `A0h` and the expiry of the stop timer can land on the same clock edge. The bench places the `A0h` write so that its strobe edge is exactly the `ERASE_CYC`-th erasing cycle, and expects a full erase together with entry into verify. It repeats the run with the strobe one cycle earlier and expects the partial pattern. After each run it sweeps every address and compares each byte with a value computed from the address and `WEAK_STRIDE`.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ERASE,
    ST_HOLD,
    ST_VERIFY
  } fe_state_t;

  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_VERIFY = 8'hA0;
endpackage

// File: rtl/flash_cmd_capture.sv
module flash_cmd_capture #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [7:0]    din,
  input  logic [AW-1:0] addr,
  output logic          stb,
  output logic [7:0]    cmd,
  output logic [AW-1:0] cmd_addr
);
  logic we_q;

  always_ff @(posedge clk) begin
    if (rst) we_q <= 1'b1;
    else     we_q <= we_n;
  end

  // rising edge of the write strobe, gated by chip enable
  assign stb      = !we_q && we_n && !ce_n;
  assign cmd      = din;
  assign cmd_addr = addr;
endmodule

// File: rtl/flash_stop_timer.sv
module flash_stop_timer #(
  parameter int ERASE_CYC = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(ERASE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(ERASE_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == LAST);
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int AW          = 4,
  parameter int WEAK_STRIDE = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          erase_full,
  input  logic          erase_part,
  input  logic [7:0]    weak_val,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          rd_valid
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells [DEPTH];

  // whole-array erase in one edge, so the store is flops, not block RAM
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst)
        cells[i] <= 8'h00;
      else if (erase_full)
        cells[i] <= 8'hFF;
      else if (erase_part)
        cells[i] <= ((i % WEAK_STRIDE) == 0) ? weak_val : 8'hFF;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? cells[rd_addr] : 8'h00;
    end
  end
endmodule

// File: rtl/flash_erase_fsm.sv
module flash_erase_fsm
  import flash_erase_pkg::*;
#(
  parameter int AW          = 4,
  parameter int ERASE_CYC   = 1250000,
  parameter int WEAK_STRIDE = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic [7:0]    weak_val,
  output logic [7:0]    dq_out,
  output logic          dq_oe
);
  fe_state_t     state_q, state_d;
  logic [AW-1:0] vaddr_q, vaddr_d;
  logic          cmd_stb;
  logic [7:0]    cmd_byte;
  logic [AW-1:0] cmd_addr;
  logic          expire;
  logic          erase_full, erase_part;
  logic          is_20, is_a0;

  flash_cmd_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .din(din), .addr(addr),
    .stb(cmd_stb), .cmd(cmd_byte), .cmd_addr(cmd_addr)
  );

  flash_stop_timer #(.ERASE_CYC(ERASE_CYC)) u_tmr (
    .clk(clk), .rst(rst), .run(state_q == ST_ERASE), .expire(expire)
  );

  assign is_20 = cmd_stb && (cmd_byte == CMD_ERASE);
  assign is_a0 = cmd_stb && (cmd_byte == CMD_VERIFY);

  always_comb begin
    state_d    = state_q;
    vaddr_d    = vaddr_q;
    erase_full = 1'b0;
    erase_part = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (is_20) state_d = ST_SETUP;
        else if (is_a0) begin
          state_d = ST_VERIFY;
          vaddr_d = cmd_addr;
        end
      end
      ST_SETUP: begin
        if (is_20)        state_d = ST_ERASE;
        else if (cmd_stb) state_d = ST_IDLE;
      end
      ST_ERASE: begin
        if (is_a0) begin
          state_d    = ST_VERIFY;
          vaddr_d    = cmd_addr;
          erase_full = expire;
          erase_part = !expire;
        end else if (expire) begin
          state_d    = ST_HOLD;
          erase_full = 1'b1;
        end
      end
      ST_HOLD: begin
        if (is_a0) begin
          state_d = ST_VERIFY;
          vaddr_d = cmd_addr;
        end
      end
      ST_VERIFY: begin
        if (is_20) state_d = ST_SETUP;
        else if (is_a0) vaddr_d = cmd_addr;
        else if (cmd_stb) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      vaddr_q <= '0;
    end else begin
      state_q <= state_d;
      vaddr_q <= vaddr_d;
    end
  end

  flash_cell_array #(.AW(AW), .WEAK_STRIDE(WEAK_STRIDE)) u_arr (
    .clk(clk), .rst(rst),
    .erase_full(erase_full), .erase_part(erase_part), .weak_val(weak_val),
    .rd_en(state_q == ST_VERIFY && !ce_n && !oe_n), .rd_addr(vaddr_q),
    .rd_data(dq_out), .rd_valid(dq_oe)
  );
endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk
  import flash_erase_pkg::*;
#(
  parameter int ERASE_CYC = 1250000
) (
  input logic       clk,
  input logic       rst,
  input fe_state_t  state,
  input logic       stb,
  input logic [7:0] cmd,
  input logic       dq_oe,
  input logic       ce_n,
  input logic       oe_n
);
  localparam int EW = $clog2(ERASE_CYC + 1) + 1;
  logic [EW-1:0] ecnt;

  always_ff @(posedge clk) begin
    if (rst || state != ST_ERASE) ecnt <= '0;
    else                          ecnt <= ecnt + 1'b1;
  end

  assert_idle_setup_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && stb && cmd == CMD_ERASE) |=> state == ST_SETUP);

  assert_setup_abort_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETUP && stb && cmd != CMD_ERASE) |=> state == ST_IDLE);

  assert_setup_erase_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETUP && stb && cmd == CMD_ERASE) |=> state == ST_ERASE);

  assert_end_verify_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERASE && stb && cmd == CMD_VERIFY) |=> state == ST_VERIFY);

  assert_stop_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERASE) |-> ecnt < EW'(ERASE_CYC));

  assert_bus_gate_R9: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(state == ST_VERIFY && !ce_n && !oe_n));

  assert_reerase_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_VERIFY && stb && cmd == CMD_ERASE) |=> state == ST_SETUP);

  assert_erase_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERASE && !(stb && cmd == CMD_VERIFY) && ecnt < EW'(ERASE_CYC - 1))
      |=> state == ST_ERASE);
endmodule

bind flash_erase_fsm flash_erase_chk #(.ERASE_CYC(ERASE_CYC)) u_chk (
  .clk(clk), .rst(rst), .state(state_q), .stb(cmd_stb), .cmd(cmd_byte),
  .dq_oe(dq_oe), .ce_n(ce_n), .oe_n(oe_n)
);

// File: tb/test_flash_erase_fsm.sv
module test_flash_erase_fsm;
  localparam int AW     = 4;
  localparam int DEPTH  = 1 << AW;
  localparam int CYC    = 40;
  localparam int STRIDE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'h00, weak_val = 8'h00;
  logic [7:0] dq_out;
  logic dq_oe;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];

  always #4 clk = ~clk;

  flash_erase_fsm #(.AW(AW), .ERASE_CYC(CYC), .WEAK_STRIDE(STRIDE)) i_flash_erase_fsm (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .din(din), .weak_val(weak_val), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // called at a negedge; the command is taken on the second posedge
  task automatic wr(input logic [7:0] b, input logic [AW-1:0] a, input logic ce);
    din = b; addr = a; ce_n = ce; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(posedge clk);
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    wr(8'hA0, a, 1'b0);
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    check({7'd0, dq_oe}, 8'd1, req);
    check(dq_out, model[a], req);
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < DEPTH; a++) rd(AW'(a), req);
  endtask

  // wait: idle negedges between the second 20h and the A0h write
  task automatic erase(input logic [7:0] w, input int wait_n);
    wr(8'h20, '0, 1'b0);
    wr(8'h20, '0, 1'b0);
    weak_val = w;
    repeat (wait_n) @(negedge clk);
    wr(8'hA0, '0, 1'b0);
  endtask

  task automatic model_erase(input bit full, input logic [7:0] w);
    for (int a = 0; a < DEPTH; a++)
      model[a] = (full || (a % STRIDE) != 0) ? 8'hFF : w;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    check({7'd0, dq_oe}, 8'd0, "R1");
    check(dq_out, 8'h00, "R1");
    // R1 R10: A0h from idle reads the reset contents
    sweep("R1_R10");
    oe_n = 1'b1;
    @(negedge clk);
    check({7'd0, dq_oe}, 8'd0, "R9");

    // R2: 20h strobes with ce_n high are dropped; an A0h later finds no erase
    wr(8'h33, '0, 1'b0);
    wr(8'h20, '0, 1'b1);
    wr(8'h20, '0, 1'b1);
    wr(8'hA0, '0, 1'b0);
    sweep("R2");

    // R3 R4: setup then a foreign byte aborts without erasing
    wr(8'h20, '0, 1'b0);
    wr(8'h5C, '0, 1'b0);
    sweep("R3_R4");

    // R8: A0h one cycle before the timer's last cycle -> partial erase
    erase(8'h5A, CYC - 3);
    model_erase(1'b0, 8'h5A);
    sweep("R8");

    // R7 R10: re-erase from verify, A0h lands on the expiry edge -> full erase
    erase(8'hC3, CYC - 2);
    model_erase(1'b1, 8'hC3);
    sweep("R7");

    // R8 R5: short erase again, then R9: no bus drive while erasing
    wr(8'h20, '0, 1'b0);
    wr(8'h20, '0, 1'b0);
    weak_val = 8'h77;
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({7'd0, dq_oe}, 8'd0, "R9");
    ce_n = 1'b1; oe_n = 1'b1;
    wr(8'hA0, 4'd5, 1'b0);
    model_erase(1'b0, 8'h77);
    // R5: address latched by the ending A0h
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    check(dq_out, 8'hFF, "R5");
    ce_n = 1'b1; oe_n = 1'b1;
    sweep("R8");

    // R6: the host stays silent well past the timer -> full erase on its own
    erase(8'h11, CYC + 20);
    model_erase(1'b1, 8'h11);
    sweep("R6");

    // R11: a stray byte mid-erase is ignored, the erase still ends as partial
    wr(8'h20, '0, 1'b0);
    wr(8'h20, '0, 1'b0);
    weak_val = 8'h99;
    @(negedge clk);
    wr(8'h55, '0, 1'b0);
    wr(8'hA0, '0, 1'b0);
    model_erase(1'b0, 8'h99);
    sweep("R11");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule